// File: doc/BRIEF.md
# Miss-buffer allocation controller

This block is the bookkeeping core of a non-blocking cache. It owns two entry pools: one holds outstanding misses and one holds outgoing writes. Each incoming request goes to exactly one pool. A request that only writes lands in the write pool. Any other request lands in the miss pool, with its address rounded down to a cache block. Every accepted allocation is tagged with a running sequence number. An allocation attempt on a full pool is refused and flagged.

Two three-bit cause masks come out of the pool activity. The first is the stall mask. Its sources are a full miss pool, a full write pool, and an external target-exhaustion condition. The CPU-side stall is high while any bit of this mask is set. The second is the memory-side request mask. Its sources are pending misses, pending writes, and an external prefetch request. A one-cycle send strobe fires when this mask leaves the empty state while no retry is outstanding.

For each stall cause the block keeps two counters: how many times stalling began, and how many cycles stalls lasted. A loadable miss-limit counter signals when a given number of reported misses has been seen.

Top module: `missbuf_alloc_ctrl`

## Requirements
- R1: A request with `req_wr`=1 and `req_rd`=0 is routed to the write pool (`alloc_pool`=1). Every other request is routed to the miss pool (`alloc_pool`=0).
- R2: A miss-pool allocation reports the request address with its low log2(BLK_BYTES) bits cleared, and a length of BLK_BYTES. A write-pool allocation reports the unmodified address and `req_size`.
- R3: Each accepted allocation carries `alloc_seq`. The sequence starts at 0 after reset and advances by exactly one per accepted allocation. Refused requests do not advance it.
- R4: A request aimed at a full pool is refused. The refusal gives `alloc_err`=1 and `alloc_vld`=0 and leaves the pool occupancy unchanged. An accepted allocation adds one entry. A service on a non-empty pool removes one entry. A service on an empty pool has no effect.
- R5: Stall mask bits are: bit 0 for miss pool full, bit 1 for write pool full, bit 2 for target exhaustion. Bit 2 is set by `tgt_full_set` and cleared by `tgt_full_clr`, and set wins if both are high. `stall` is 1 exactly when the mask is nonzero.
- R6: A pool's stall bit is set when an accepted allocation leaves that pool full. The bit is cleared only by a service that takes the pool from full to not full.
- R7: Request mask bits are: bit 0 for miss, bit 1 for write, bit 2 for prefetch. An accepted allocation with `req_bus`=1 sets its pool's bit. A service that leaves its pool with no entries clears that pool's bit. Bit 2 follows `pf_req_set` and `pf_req_clr`, and set wins if both are high.
- R8: `send_strobe` is high for one cycle after an edge at which the request mask went from zero to nonzero while `mem_retry_pend` was 0. At no other time is it high.
- R9: When the stall mask goes from zero to nonzero, the event counter of the lowest-numbered cause set at that edge increments by one. Counter c occupies `blk_evt[c*EVW +: EVW]`.
- R10: When the stall mask returns to zero, the number of cycles it was nonzero is added to the cycle counter of the lowest-numbered cause cleared at that edge. Counter c occupies `blk_cyc[c*CYW +: CYW]`.
- R11: `lim_load` loads the miss limit from `lim_value`, and load has priority. Each `miss_rpt` decrements a nonzero limit. `lim_done` is high for one cycle after the decrement that reaches zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Allocation request this cycle |
| req_addr | input | AW | Request address |
| req_size | input | SW | Request size in bytes |
| req_rd | input | 1 | Request reads |
| req_wr | input | 1 | Request writes |
| req_bus | input | 1 | Allocation should raise a memory-side request |
| svc_valid | input | 1 | One entry goes into service |
| svc_pool | input | 1 | Pool of the serviced entry (0 miss, 1 write) |
| tgt_full_set | input | 1 | Target exhaustion begins |
| tgt_full_clr | input | 1 | Target exhaustion ends |
| pf_req_set | input | 1 | Prefetch wants the memory side |
| pf_req_clr | input | 1 | Prefetch request withdrawn |
| mem_retry_pend | input | 1 | Memory side has a retry outstanding |
| lim_load | input | 1 | Load miss limit |
| lim_value | input | LMW | Miss limit value |
| miss_rpt | input | 1 | One miss reported |
| alloc_vld | output | 1 | Allocation accepted last cycle |
| alloc_pool | output | 1 | Pool of the last accepted allocation |
| alloc_addr | output | AW | Address of the last accepted allocation |
| alloc_len | output | SW | Length of the last accepted allocation |
| alloc_seq | output | QW | Sequence tag of the last accepted allocation |
| alloc_err | output | 1 | Request refused last cycle (pool full) |
| stall | output | 1 | CPU-side stall |
| blk_mask | output | 3 | Stall cause mask |
| bus_mask | output | 3 | Memory-side request cause mask |
| send_strobe | output | 1 | One-cycle send trigger |
| blk_evt | output | 3*EVW | Per-cause stall event counters |
| blk_cyc | output | 3*CYW | Per-cause stalled cycle counters |
| lim_done | output | 1 | Miss limit reached |

## Verification
Every result is registered. All outputs, including masks, strobes, tags and counters, reflect the inputs sampled at one rising edge and become visible right after that same edge. Nothing takes longer than one cycle. The bench drives each stimulus on a falling edge and compares all outputs on the next falling edge against an arithmetic model. That model counts pool occupancy and the edge index, so stall durations are predicted as differences of edge indices. Directed fill-and-drain sequences and a long pseudo-random sweep run on the default small configuration of four miss entries and two write entries.

// File: rtl/mbac_pkg.sv
package mbac_pkg;
  localparam int NCAUSE = 3;
  localparam int NPOOL  = 2;
  localparam int CIDX_W = 2;

  typedef enum logic [CIDX_W-1:0] {
    CAUSE_MISS = 2'd0,
    CAUSE_WBUF = 2'd1,
    CAUSE_AUX  = 2'd2
  } cause_e;
endpackage

// File: rtl/mbac_pool.sv
module mbac_pool #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic alloc_i,
  input  logic svc_i,
  output logic accept_o,
  output logic reject_o,
  output logic blk_set_o,
  output logic blk_clr_o,
  output logic drained_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          full_q, svc_eff, cnt_en;

  always_comb begin
    full_q    = (cnt_q == CW'(DEPTH));
    svc_eff   = svc_i && (cnt_q != '0);
    accept_o  = alloc_i && !full_q;
    reject_o  = alloc_i && full_q;
    cnt_d     = cnt_q + CW'(accept_o) - CW'(svc_eff);
    cnt_en    = accept_o || svc_eff;
    blk_set_o = accept_o && (cnt_d == CW'(DEPTH));
    blk_clr_o = svc_eff && full_q && (cnt_d != CW'(DEPTH));
    drained_o = svc_eff && (cnt_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assert_occ_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  assert_reject_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_i && full_q && !svc_i) |=> $stable(cnt_q));
endmodule

// File: rtl/mbac_busreq.sv
module mbac_busreq #(
  parameter int NC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NC-1:0] set_i,
  input  logic [NC-1:0] clr_i,
  input  logic          retry_i,
  output logic [NC-1:0] mask_o,
  output logic          send_o
);
  logic [NC-1:0] mask_q, mask_d;
  logic          send_q, send_d;

  always_comb begin
    mask_d = (mask_q & ~clr_i) | set_i;
    send_d = (mask_q == '0) && (mask_d != '0) && !retry_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      send_q <= 1'b0;
    end else begin
      mask_q <= mask_d;
      send_q <= send_d;
    end
  end

  assign mask_o = mask_q;
  assign send_o = send_q;

  assert_send_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    send_q |=> !send_q);
  assert_send_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    send_q |-> (mask_q != '0));
endmodule

// File: rtl/mbac_blkstat.sv
module mbac_blkstat #(
  parameter int NC  = 3,
  parameter int EVW = 8,
  parameter int CYW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NC-1:0]     set_i,
  input  logic [NC-1:0]     clr_i,
  output logic [NC-1:0]     mask_o,
  output logic              stall_o,
  output logic [NC*EVW-1:0] evt_o,
  output logic [NC*CYW-1:0] cyc_o
);
  localparam int IW = (NC > 1) ? $clog2(NC) : 1;

  logic [NC-1:0]  mask_q, mask_d;
  logic           going_on, going_off;
  logic [IW-1:0]  on_idx, off_idx;
  logic [CYW-1:0] now_q, start_q, elapsed;

  always_comb begin
    mask_d    = (mask_q & ~clr_i) | set_i;
    going_on  = (mask_q == '0) && (mask_d != '0);
    going_off = (mask_q != '0) && (mask_d == '0);
    on_idx    = '0;
    off_idx   = '0;
    for (int i = NC - 1; i >= 0; i--) begin
      if (mask_d[i]) on_idx  = IW'(i);
      if (mask_q[i]) off_idx = IW'(i);
    end
    elapsed = now_q - start_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      now_q   <= '0;
      start_q <= '0;
    end else begin
      mask_q <= mask_d;
      now_q  <= now_q + 1'b1;
      if (going_on) start_q <= now_q;
    end
  end

  for (genvar c = 0; c < NC; c++) begin : g_cause
    logic [EVW-1:0] evt_q;
    logic [CYW-1:0] cyc_q;
    logic           evt_en, cyc_en;
    assign evt_en = going_on  && (on_idx  == IW'(c));
    assign cyc_en = going_off && (off_idx == IW'(c));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        evt_q <= '0;
        cyc_q <= '0;
      end else begin
        if (evt_en) evt_q <= evt_q + 1'b1;
        if (cyc_en) cyc_q <= cyc_q + elapsed;
      end
    end
    assign evt_o[c*EVW +: EVW] = evt_q;
    assign cyc_o[c*CYW +: CYW] = cyc_q;
  end

  assign mask_o  = mask_q;
  assign stall_o = (mask_q != '0);

  assert_evt_only_on_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q != '0) |=> $stable(evt_o));
  assert_cyc_only_on_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |=> $stable(cyc_o));
endmodule

// File: rtl/missbuf_alloc_ctrl.sv
module missbuf_alloc_ctrl
  import mbac_pkg::*;
#(
  parameter int AW         = 32,
  parameter int SW         = 8,
  parameter int BLK_BYTES  = 32,
  parameter int MISS_DEPTH = 4,
  parameter int WBUF_DEPTH = 2,
  parameter int QW         = 16,
  parameter int EVW        = 8,
  parameter int CYW        = 16,
  parameter int LMW        = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [AW-1:0]         req_addr,
  input  logic [SW-1:0]         req_size,
  input  logic                  req_rd,
  input  logic                  req_wr,
  input  logic                  req_bus,
  input  logic                  svc_valid,
  input  logic                  svc_pool,
  input  logic                  tgt_full_set,
  input  logic                  tgt_full_clr,
  input  logic                  pf_req_set,
  input  logic                  pf_req_clr,
  input  logic                  mem_retry_pend,
  input  logic                  lim_load,
  input  logic [LMW-1:0]        lim_value,
  input  logic                  miss_rpt,
  output logic                  alloc_vld,
  output logic                  alloc_pool,
  output logic [AW-1:0]         alloc_addr,
  output logic [SW-1:0]         alloc_len,
  output logic [QW-1:0]         alloc_seq,
  output logic                  alloc_err,
  output logic                  stall,
  output logic [NCAUSE-1:0]     blk_mask,
  output logic [NCAUSE-1:0]     bus_mask,
  output logic                  send_strobe,
  output logic [NCAUSE*EVW-1:0] blk_evt,
  output logic [NCAUSE*CYW-1:0] blk_cyc,
  output logic                  lim_done
);
  localparam int OFFW = $clog2(BLK_BYTES);

  logic             to_wbuf;
  logic [NPOOL-1:0] p_alloc, p_svc, p_acc, p_rej, p_bset, p_bclr, p_drain;
  logic             any_acc, any_rej;
  logic [AW-1:0]    addr_d;
  logic [SW-1:0]    len_d;

  logic             vld_q, err_q, pool_q, done_q, done_d;
  logic [AW-1:0]    addr_q;
  logic [SW-1:0]    len_q;
  logic [QW-1:0]    tag_q, seq_q;
  logic [LMW-1:0]   lim_q, lim_d;
  logic             lim_en;

  // R1: write-only requests go to the write pool
  always_comb begin
    to_wbuf    = req_wr && !req_rd;
    p_alloc[0] = req_valid && !to_wbuf;
    p_alloc[1] = req_valid && to_wbuf;
    p_svc[0]   = svc_valid && !svc_pool;
    p_svc[1]   = svc_valid && svc_pool;
  end

  for (genvar p = 0; p < NPOOL; p++) begin : g_pool
    mbac_pool #(.DEPTH((p == 0) ? MISS_DEPTH : WBUF_DEPTH)) u_pool (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc_i   (p_alloc[p]),
      .svc_i     (p_svc[p]),
      .accept_o  (p_acc[p]),
      .reject_o  (p_rej[p]),
      .blk_set_o (p_bset[p]),
      .blk_clr_o (p_bclr[p]),
      .drained_o (p_drain[p])
    );
  end

  // R2: block-aligned miss entries, raw write entries
  always_comb begin
    any_acc = |p_acc;
    any_rej = |p_rej;
    if (to_wbuf) begin
      addr_d = req_addr;
      len_d  = req_size;
    end else begin
      addr_d = {req_addr[AW-1:OFFW], OFFW'(0)};
      len_d  = SW'(BLK_BYTES);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
      pool_q <= 1'b0;
      addr_q <= '0;
      len_q  <= '0;
      tag_q  <= '0;
      seq_q  <= '0;
    end else begin
      vld_q <= any_acc;
      err_q <= any_rej;
      if (any_acc) begin
        pool_q <= to_wbuf;
        addr_q <= addr_d;
        len_q  <= len_d;
        tag_q  <= seq_q;
        seq_q  <= seq_q + 1'b1;
      end
    end
  end

  mbac_blkstat #(.NC(NCAUSE), .EVW(EVW), .CYW(CYW)) u_blkstat (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   ({tgt_full_set, p_bset}),
    .clr_i   ({tgt_full_clr, p_bclr}),
    .mask_o  (blk_mask),
    .stall_o (stall),
    .evt_o   (blk_evt),
    .cyc_o   (blk_cyc)
  );

  mbac_busreq #(.NC(NCAUSE)) u_busreq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   ({pf_req_set, p_acc & {NPOOL{req_bus}}}),
    .clr_i   ({pf_req_clr, p_drain}),
    .retry_i (mem_retry_pend),
    .mask_o  (bus_mask),
    .send_o  (send_strobe)
  );

  // R11: miss limit
  always_comb begin
    lim_en = lim_load || (miss_rpt && (lim_q != '0));
    lim_d  = lim_load ? lim_value : lim_q - 1'b1;
    done_d = !lim_load && miss_rpt && (lim_q == LMW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (lim_en) lim_q <= lim_d;
    end
  end

  assign alloc_vld  = vld_q;
  assign alloc_err  = err_q;
  assign alloc_pool = pool_q;
  assign alloc_addr = addr_q;
  assign alloc_len  = len_q;
  assign alloc_seq  = tag_q;
  assign lim_done   = done_q;

  assert_vld_err_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(vld_q && err_q));
  assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !any_acc |=> $stable(seq_q));
  assert_done_at_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (lim_q == '0));
endmodule

// File: tb/missbuf_alloc_ctrl_bench.sv
module missbuf_alloc_ctrl_bench;
  localparam int AW = 32, SW = 8, BLK = 32, QW = 16, EVW = 8, CYW = 16, LMW = 16;
  localparam int DEP0 = 4, DEP1 = 2;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic req_valid, req_rd, req_wr, req_bus, svc_valid, svc_pool;
  logic tgt_full_set, tgt_full_clr, pf_req_set, pf_req_clr, mem_retry_pend;
  logic lim_load, miss_rpt;
  logic [AW-1:0] req_addr;
  logic [SW-1:0] req_size;
  logic [LMW-1:0] lim_value;
  logic alloc_vld, alloc_pool, alloc_err, stall, send_strobe, lim_done;
  logic [AW-1:0] alloc_addr;
  logic [SW-1:0] alloc_len;
  logic [QW-1:0] alloc_seq;
  logic [2:0] blk_mask, bus_mask;
  logic [3*EVW-1:0] blk_evt;
  logic [3*CYW-1:0] blk_cyc;

  missbuf_alloc_ctrl u_missbuf_alloc_ctrl (.*);

  int nchk = 0, nbad = 0;
  bit finished = 0;

  // bench model state
  int occ[2];
  int seq, tk, start_tk, lim;
  int evt[3], cyc[3];
  logic [2:0] mm, bm;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    req_valid = 0; req_rd = 0; req_wr = 0; req_bus = 0; req_addr = '0; req_size = '0;
    svc_valid = 0; svc_pool = 0; tgt_full_set = 0; tgt_full_clr = 0;
    pf_req_set = 0; pf_req_clr = 0; mem_retry_pend = 0;
    lim_load = 0; lim_value = '0; miss_rpt = 0;
  endtask

  // One cycle: inputs are already driven; predict, clock, compare.
  task automatic tick();
    int p, nocc[2], dep[2], lo;
    bit acc, rej, sve, exp_send, exp_done;
    logic [2:0] bset, bclr, nm, nb;
    logic [AW-1:0] e_addr;
    logic [SW-1:0] e_len;
    dep[0] = DEP0; dep[1] = DEP1;
    p = (req_wr && !req_rd) ? 1 : 0;
    acc = req_valid && (occ[p] != dep[p]);
    rej = req_valid && (occ[p] == dep[p]);
    sve = svc_valid && (occ[svc_pool] != 0);
    nocc[0] = occ[0]; nocc[1] = occ[1];
    if (acc) nocc[p]++;
    if (sve) nocc[svc_pool]--;
    bset = '0; bclr = '0;
    for (int q = 0; q < 2; q++) begin
      if (acc && p == q && nocc[q] == dep[q]) bset[q] = 1;
      if (sve && svc_pool == q && occ[q] == dep[q] && nocc[q] != dep[q]) bclr[q] = 1;
    end
    bset[2] = tgt_full_set; bclr[2] = tgt_full_clr;
    nm = (mm & ~bclr) | bset;
    nb = bm & ~{pf_req_clr, 1'b0, 1'b0};
    for (int q = 0; q < 2; q++)
      if (sve && svc_pool == q && nocc[q] == 0) nb[q] = 0;
    if (acc && req_bus) nb[p] = 1;
    if (pf_req_set) nb[2] = 1;
    exp_send = (bm == 0) && (nb != 0) && !mem_retry_pend;
    e_addr = p ? req_addr : {req_addr[AW-1:5], 5'b0};
    e_len  = p ? req_size : SW'(BLK);
    exp_done = 0;
    if (lim_load) lim = lim_value;
    else if (miss_rpt && lim != 0) begin lim--; exp_done = (lim == 0); end
    @(posedge clk);
    @(negedge clk);
    // R4 refusal and acceptance
    chk("R4 alloc_vld", alloc_vld, acc);
    chk("R4 alloc_err", alloc_err, rej);
    if (acc) begin
      chk("R1 alloc_pool", alloc_pool, p);
      chk("R2 alloc_addr", alloc_addr, e_addr);
      chk("R2 alloc_len", alloc_len, e_len);
      chk("R3 alloc_seq", alloc_seq, seq[QW-1:0]);
      seq++;
    end
    if (mm == 0 && nm != 0) begin
      lo = nm[0] ? 0 : (nm[1] ? 1 : 2);
      evt[lo]++; start_tk = tk;
    end
    if (mm != 0 && nm == 0) begin
      lo = mm[0] ? 0 : (mm[1] ? 1 : 2);
      cyc[lo] += tk - start_tk;
    end
    chk("R5 R6 blk_mask", blk_mask, nm);
    chk("R5 stall", stall, nm != 0);
    chk("R7 bus_mask", bus_mask, nb);
    chk("R8 send_strobe", send_strobe, exp_send);
    for (int c = 0; c < 3; c++) begin
      chk("R9 blk_evt", blk_evt[c*EVW +: EVW], evt[c][EVW-1:0]);
      chk("R10 blk_cyc", blk_cyc[c*CYW +: CYW], cyc[c][CYW-1:0]);
    end
    chk("R11 lim_done", lim_done, exp_done);
    occ[0] = nocc[0]; occ[1] = nocc[1];
    mm = nm; bm = nb; tk++;
    idle_inputs();
  endtask

  task automatic do_req(input logic [AW-1:0] a, input logic [SW-1:0] s,
                        input bit rd, input bit wr, input bit bus);
    req_valid = 1; req_addr = a; req_size = s; req_rd = rd; req_wr = wr; req_bus = bus;
    tick();
  endtask

  task automatic do_svc(input bit pool);
    svc_valid = 1; svc_pool = pool;
    tick();
  endtask

  initial begin : watchdog
    #(4 * 150000);
    if (!finished) begin
      nchk++; nbad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] r;
    idle_inputs();
    occ[0] = 0; occ[1] = 0; seq = 0; tk = 0; start_tk = 0; lim = 0;
    for (int c = 0; c < 3; c++) begin evt[c] = 0; cyc[c] = 0; end
    mm = 0; bm = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // reset state
    chk("R5 reset stall", stall, 0);
    chk("R7 reset bus_mask", bus_mask, 0);
    chk("R8 reset send", send_strobe, 0);
    chk("R4 reset alloc_vld", alloc_vld, 0);
    chk("R9 reset evt", blk_evt, 0);

    // R1/R2 read-write combos, then R6 fill miss pool
    do_req(32'h1234_5677, 8'd7, 1, 0, 1);
    do_req(32'h0000_0FFF, 8'd3, 1, 1, 0);
    do_req(32'hABCD_0003, 8'd5, 0, 0, 0);
    do_req(32'h0000_0040, 8'd9, 1, 0, 1);
    do_req(32'h0000_0041, 8'd9, 1, 0, 1);   // R4 refused: miss pool full
    do_req(32'h5555_0001, 8'd4, 0, 1, 1);   // R1 write pool
    do_req(32'h5555_0011, 8'd6, 0, 1, 1);   // R6 write pool full
    do_req(32'h5555_0021, 8'd2, 0, 1, 0);   // R4 refused
    tgt_full_set = 1; tick();
    do_svc(0);
    do_svc(1);
    tgt_full_clr = 1; tick();                // R10 cycles to aux cause
    tick();
    do_svc(1); do_svc(1);                     // R4 service on empty is ignored
    for (int i = 0; i < 5; i++) do_svc(0);
    // R8 retry suppresses strobe
    mem_retry_pend = 1; pf_req_set = 1; tick();
    pf_req_clr = 1; tick();
    // R11 miss limit
    lim_load = 1; lim_value = 16'd3; tick();
    for (int i = 0; i < 4; i++) begin miss_rpt = 1; tick(); end

    // pseudo-random sweep
    r = 32'h1ACE_B00C;
    for (int i = 0; i < 4000; i++) begin
      r ^= r << 13; r ^= r >> 17; r ^= r << 5;
      req_valid = r[0] | r[1];
      req_rd = r[2]; req_wr = r[3]; req_bus = r[4];
      req_addr = {r[31:8], r[7:0] ^ 8'h5A};
      req_size = {3'b0, r[12:8]};
      svc_valid = r[13] & r[14] | r[15] & r[16];
      svc_pool = r[17];
      tgt_full_set = (r[20:18] == 3'd0);
      tgt_full_clr = (r[22:21] == 2'd0);
      pf_req_set = (r[25:23] == 3'd1);
      pf_req_clr = (r[27:26] == 2'd1);
      mem_retry_pend = r[28];
      lim_load = (r[31:29] == 3'd7) && r[5];
      lim_value = {13'd0, r[8:6]};
      miss_rpt = r[9];
      tick();
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule